// File: doc/BRIEF.md
# Temperature-Driven Wiper Update Controller

This block keeps the wiper setting of a digital potentiometer in step with a periodic temperature measurement. Each time a conversion finishes, the block turns the temperature code into a row index of a lookup table, reads that row, and loads the wiper. Depending on the mode the value loaded is the row entry alone or the row entry plus an offset, and the sum stops at full scale. A small control register lets the host freeze all automatic updates (standby), take the wiper under manual control, or take the table index under manual control so that it can walk the table itself.

The host reaches the index register (08h), the wiper register (09h) and the control register (0Ah) through a simple write/read port that a serial-bus slave drives. The table itself is outside the block and answers a read address on the same cycle. The block's own reset is asynchronous on entry and leaves reset two clock edges after the reset input is released.

Top module: `wiper_ctrl_top`

## Requirements
- R1: After reset the index register, the wiper register and the control register all read 00h. Any address other than 08h, 09h and 0Ah reads 00h.
- R2: In table mode (mode 01) and table-adder mode (mode 10 or 11), when control bit 1 is 0, a conversion-done pulse sets the index to min(code >> 1, 71). The new index appears on the table address output one cycle after the pulse.
- R3: In table mode with control bit 2 at 0, the wiper loads the table entry at the new index two cycles after the done pulse.
- R4: In table-adder mode the wiper loads the entry plus the offset input. A sum above FFh gives FFh.
- R5: With control bit 2 at 1 in a table mode, conversions never change the wiper, and host writes to 09h set it directly.
- R6: With control bit 1 at 1 in a table mode, conversions never change the index. Host writes to 08h set it, and any value above 71 is stored as 71.
- R7: In a table mode, a host write to 09h is ignored while bit 2 is 0, and a host write to 08h is ignored while bit 1 is 0.
- R8: In manual mode (mode 00) conversions change nothing, and host writes to 08h and 09h take effect whatever bits 2:1 hold.
- R9: While control bit 0 (standby) is 1, conversions change neither the index nor the wiper, and register writes are still accepted.
- R10: After standby is cleared, the first done pulse is discarded. Later pulses update the index and the wiper as usual.
- R11: A write to 0Ah stores bits 2:0. Reading 0Ah returns those bits with bits 7:3 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done_i | input | 1 | One-cycle pulse when a temperature conversion finishes |
| temp_code_i | input | 8 | Temperature code, valid with the done pulse |
| mode_i | input | 2 | 00 manual, 01 table, 1x table-adder |
| offset_i | input | 8 | Offset added in table-adder mode |
| tbl_addr_o | output | 7 | Table read address (the index register) |
| tbl_data_i | input | 8 | Table entry at tbl_addr_o, same cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| wiper_o | output | 8 | Wiper register |

## Verification
The bench covers several corner cases, each tied to a specific design error:
- Codes whose shifted value lands above row 71, and host index writes above 71. A design without the clamp would read past the end of the table.
- Offsets large enough to overflow the sum. A design that wraps would give a small wiper value where FFh is expected.
- The done pulse just after standby is cleared, with a second pulse after it. A design that applies the stale frame would move the wiper one conversion too early.
- Host writes to 08h or 09h that arrive while automatic updates own those registers, and the same writes in manual mode. A design that mixes up the disable bits would either lose the writes or let them override the automatic path.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam logic [7:0] ADDR_IDX = 8'h08;
  localparam logic [7:0] ADDR_WIP = 8'h09;
  localparam logic [7:0] ADDR_CTL = 8'h0A;

  localparam logic [1:0] MODE_MANUAL = 2'b00;

  typedef struct packed {
    logic wip_hold;   // bit 2: wiper under host control
    logic idx_hold;   // bit 1: index under host control
    logic stby;       // bit 0: standby
  } ctl_t;
endpackage

// File: rtl/wpr_addr_map.sv
module wpr_addr_map #(
  parameter int IN_W  = 8,
  parameter int SHIFT = 1,
  parameter int DEPTH = 72,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [IN_W-1:0] code_i,
  output logic [AW-1:0]   idx_o
);
  localparam logic [IN_W-1:0] TOP = IN_W'(DEPTH - 1);

  logic [IN_W-1:0] shifted;

  always_comb begin
    shifted = code_i >> SHIFT;
    if (shifted > TOP) idx_o = TOP[AW-1:0];
    else               idx_o = shifted[AW-1:0];
  end
endmodule

// File: rtl/wpr_sat_add.sv
module wpr_sat_add #(
  parameter int W        = 8,
  parameter bit SATURATE = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] full;

  assign full = {1'b0, a_i} + {1'b0, b_i};

  generate
    if (SATURATE) begin : g_sat
      assign sum_o = full[W] ? {W{1'b1}} : full[W-1:0];
    end else begin : g_wrap
      assign sum_o = full[W-1:0];
    end
  endgenerate
endmodule

// File: rtl/wpr_frame_seq.sv
module wpr_frame_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic stby_i,
  input  logic run_i,
  output logic take_o,
  output logic load_o
);
  logic skip_q, skip_d;
  logic pend_q;

  // A frame is trusted only if it started after standby ended.
  assign take_o = done_i & ~stby_i & ~skip_q & run_i;
  assign load_o = pend_q & ~stby_i & run_i;

  always_comb begin
    skip_d = skip_q;
    if (stby_i)      skip_d = 1'b1;
    else if (done_i) skip_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      skip_q <= skip_d;
      pend_q <= take_o;
    end
  end
endmodule

// File: rtl/wiper_ctrl_top.sv
module wiper_ctrl_top
  import wpr_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int DATA_W     = 8,
  parameter int TBL_DEPTH  = 72,
  parameter int ADDR_SHIFT = 1,
  localparam int AW        = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] offset_i,
  output logic [AW-1:0]     tbl_addr_o,
  input  logic [DATA_W-1:0] tbl_data_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [DATA_W-1:0] wiper_o
);
  // reset: asynchronous entry, synchronous release
  logic [1:0] rst_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  ctl_t              ctl_q, ctl_d;
  logic [AW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] wip_q, wip_d;
  logic              idx_en, wip_en;

  logic tbl_mode, add_mode;
  logic hw_idx, hw_wip, hw_ctl;
  logic take, load;
  logic auto_idx, host_idx, auto_wip, host_wip;
  logic [AW-1:0]     temp_idx, host_idx_val;
  logic [DATA_W-1:0] sum, load_val;

  assign tbl_mode = (mode_i != MODE_MANUAL);
  assign add_mode = mode_i[1];
  assign hw_idx   = reg_we_i && (reg_addr_i == ADDR_IDX);
  assign hw_wip   = reg_we_i && (reg_addr_i == ADDR_WIP);
  assign hw_ctl   = reg_we_i && (reg_addr_i == ADDR_CTL);

  wpr_frame_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_sn),
    .done_i (conv_done_i),
    .stby_i (ctl_q.stby),
    .run_i  (tbl_mode),
    .take_o (take),
    .load_o (load)
  );

  wpr_addr_map #(.IN_W(TEMP_W), .SHIFT(ADDR_SHIFT), .DEPTH(TBL_DEPTH), .AW(AW)) u_tmap (
    .code_i (temp_code_i),
    .idx_o  (temp_idx)
  );

  wpr_addr_map #(.IN_W(DATA_W), .SHIFT(0), .DEPTH(TBL_DEPTH), .AW(AW)) u_hmap (
    .code_i (reg_wdata_i),
    .idx_o  (host_idx_val)
  );

  wpr_sat_add #(.W(DATA_W), .SATURATE(1'b1)) u_add (
    .a_i   (tbl_data_i),
    .b_i   (offset_i),
    .sum_o (sum)
  );

  assign load_val = add_mode ? sum : tbl_data_i;

  // next-state logic
  always_comb begin
    auto_idx = take & ~ctl_q.idx_hold;
    host_idx = hw_idx & (~tbl_mode | ctl_q.idx_hold);
    auto_wip = load & ~ctl_q.wip_hold;
    host_wip = hw_wip & (~tbl_mode | ctl_q.wip_hold);

    idx_en = auto_idx | host_idx;
    idx_d  = auto_idx ? temp_idx : host_idx_val;
    wip_en = auto_wip | host_wip;
    wip_d  = auto_wip ? load_val : reg_wdata_i;
    ctl_d  = hw_ctl ? ctl_t'(reg_wdata_i[2:0]) : ctl_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctl_q <= '0;
      idx_q <= '0;
      wip_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      if (idx_en) idx_q <= idx_d;
      if (wip_en) wip_q <= wip_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_IDX: reg_rdata_o = DATA_W'(idx_q);
      ADDR_WIP: reg_rdata_o = wip_q;
      ADDR_CTL: reg_rdata_o = DATA_W'(ctl_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign tbl_addr_o = idx_q;
  assign wiper_o    = wip_q;
endmodule

// File: rtl/wpr_chk.sv
module wpr_chk
  import wpr_pkg::*;
#(
  parameter int AW    = 7,
  parameter int DW    = 8,
  parameter int DEPTH = 72
) (
  input logic          clk,
  input logic          rst_sn,
  input logic [1:0]    mode,
  input logic [2:0]    ctl,
  input logic          reg_we,
  input logic [7:0]    reg_addr,
  input logic [DW-1:0] rdata,
  input logic [AW-1:0] tbl_addr,
  input logic [DW-1:0] wiper
);
  logic w_idx, w_wip;
  assign w_idx = reg_we && (reg_addr == ADDR_IDX);
  assign w_wip = reg_we && (reg_addr == ADDR_WIP);

  // R11
  rsv_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_addr == ADDR_CTL) |-> (rdata[DW-1:3] == '0));

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    tbl_addr <= AW'(DEPTH - 1));

  // R5
  wiper_manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctl[2] && !w_wip) |=> $stable(wiper));

  // R6
  idx_manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ((mode != MODE_MANUAL) && ctl[1] && !w_idx) |=> $stable(tbl_addr));

  // R8
  manual_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ((mode == MODE_MANUAL) && !w_idx && !w_wip) |=> ($stable(wiper) && $stable(tbl_addr)));

  // R9
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctl[0] && !w_idx && !w_wip) |=> ($stable(wiper) && $stable(tbl_addr)));
endmodule

bind wiper_ctrl_top wpr_chk #(.AW(AW), .DW(DATA_W), .DEPTH(TBL_DEPTH)) u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .mode     (mode_i),
  .ctl      (ctl_q),
  .reg_we   (reg_we_i),
  .reg_addr (reg_addr_i),
  .rdata    (reg_rdata_o),
  .tbl_addr (tbl_addr_o),
  .wiper    (wiper_o)
);

// File: tb/tb_wiper_ctrl_top.sv
`timescale 1ns/1ps
module tb_wiper_ctrl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       done = 1'b0;
  logic [7:0] temp = '0;
  logic [1:0] mode = 2'b00;
  logic [7:0] offs = '0;
  logic [6:0] taddr;
  logic [7:0] tdata;
  logic       we = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] wiper;

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  function automatic logic [7:0] tbl_val(input int a);
    return 8'((a * 29 + 100) % 256);
  endfunction

  assign tdata = tbl_val(int'(taddr));

  wiper_ctrl_top dut (
    .clk(clk), .rst_n(rst_n), .conv_done_i(done), .temp_code_i(temp),
    .mode_i(mode), .offset_i(offs), .tbl_addr_o(taddr), .tbl_data_i(tdata),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .wiper_o(wiper)
  );

  // behavioural reference model
  int   m_rs = 0;
  int   m_ctl = 0, m_idx = 0, m_wip = 0;
  bit   m_pend = 0, m_skip = 0;

  function automatic int exp_rdata(input int a);
    if (a == 8'h08) return m_idx;
    if (a == 8'h09) return m_wip;
    if (a == 8'h0A) return m_ctl;
    return 0;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs = 0; m_ctl = 0; m_idx = 0; m_wip = 0; m_pend = 0; m_skip = 0;
    end else begin
      if (m_rs >= 2) begin
        bit tm, stby, take, load;
        int n_ctl, n_idx, n_wip, v;
        tm   = (mode != 0);
        stby = m_ctl[0];
        take = done && !stby && !m_skip && tm;
        load = m_pend && !stby && tm;
        n_ctl = m_ctl; n_idx = m_idx; n_wip = m_wip;
        if (we && addr == 8'h0A) n_ctl = wdata & 7;
        if (take && !m_ctl[1]) begin
          n_idx = temp / 2;
          if (n_idx > 71) n_idx = 71;
        end else if (we && addr == 8'h08 && (!tm || m_ctl[1])) begin
          n_idx = (wdata > 71) ? 71 : wdata;
        end
        if (load && !m_ctl[2]) begin
          v = tbl_val(m_idx);
          if (mode[1]) begin
            v = v + offs;
            if (v > 255) v = 255;
          end
          n_wip = v;
        end else if (we && addr == 8'h09 && (!tm || m_ctl[2])) begin
          n_wip = wdata;
        end
        if (stby) m_skip = 1;
        else if (done) m_skip = 0;
        m_pend = take;
        m_ctl = n_ctl; m_idx = n_idx; m_wip = n_wip;
      end else begin
        m_ctl = 0; m_idx = 0; m_wip = 0; m_pend = 0; m_skip = 0;
      end
      if (m_rs < 2) m_rs++;
    end
    #1;
    if (!finished) begin
      chk("wiper", int'(wiper), m_wip);
      chk("tbl_addr", int'(taddr), m_idx);
      chk("rdata", int'(rdata), exp_rdata(int'(addr)));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic conv(input logic [7:0] t);
    @(negedge clk); done = 1'b1; temp = t;
    @(negedge clk); done = 1'b0;
    idle(3);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
    idle(1);
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); addr = a;
    idle(1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset values and unmapped reads
    idle(3); rst_n = 1'b1; idle(4);
    cur_req = "R1";
    rd(8'h08); rd(8'h09); rd(8'h0A); rd(8'h05); rd(8'hFF);

    // R11: control register keeps only bits 2:0
    cur_req = "R11";
    wr(8'h0A, 8'hFE); rd(8'h0A);
    wr(8'h0A, 8'h00); rd(8'h0A);

    // R2 / R3: table mode, including clamp at row 71
    mode = 2'b01;
    cur_req = "R2"; conv(8'd0); conv(8'd37); conv(8'd143); conv(8'd200); conv(8'd255);
    cur_req = "R3"; conv(8'd90); conv(8'd17);
    @(negedge clk); done = 1'b1; temp = 8'd60;
    @(negedge clk); temp = 8'd20;
    @(negedge clk); done = 1'b0; idle(3);

    // R4: adder mode with and without overflow
    mode = 2'b10; cur_req = "R4";
    offs = 8'd0;   conv(8'd40);
    offs = 8'd30;  conv(8'd80);
    offs = 8'd250; conv(8'd120); conv(8'd10);
    mode = 2'b11;  conv(8'd66);

    // R7: writes ignored while automatic updates own the registers
    mode = 2'b01; cur_req = "R7";
    wr(8'h09, 8'h5A); wr(8'h08, 8'd3); rd(8'h08); rd(8'h09);

    // R5: wiper under host control
    cur_req = "R5";
    wr(8'h0A, 8'h04); conv(8'd100); wr(8'h09, 8'hC3); rd(8'h09); conv(8'd30);

    // R6: index under host control, clamped host writes
    cur_req = "R6";
    wr(8'h0A, 8'h02); wr(8'h08, 8'd40); conv(8'd200);
    wr(8'h08, 8'd200); rd(8'h08); conv(8'd4);

    // R8: manual mode
    mode = 2'b00; cur_req = "R8";
    wr(8'h0A, 8'h00); conv(8'd150);
    wr(8'h08, 8'd12); wr(8'h09, 8'h77); rd(8'h08); rd(8'h09);

    // R9: standby freezes updates, registers still writable
    mode = 2'b01; cur_req = "R9";
    wr(8'h0A, 8'h01); conv(8'd50); conv(8'd140);
    wr(8'h0A, 8'h05); wr(8'h09, 8'h11); rd(8'h09);

    // R10: first frame after standby discarded
    cur_req = "R10";
    wr(8'h0A, 8'h00); conv(8'd70); conv(8'd110); conv(8'd24);

    // mixed traffic against the model
    cur_req = "R3";
    void'($urandom(7));
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      done  = ($urandom % 4) == 0;
      temp  = 8'($urandom);
      offs  = 8'($urandom);
      we    = ($urandom % 5) == 0;
      addr  = 8'h08 + 8'($urandom % 3);
      wdata = 8'($urandom);
      if ((addr == 8'h0A) && (($urandom % 3) != 0)) wdata = wdata & 8'hFE;
      if ((i % 150) == 0) mode = 2'($urandom);
    end
    @(negedge clk); done = 1'b0; we = 1'b0;
    idle(4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule